// File: doc/BRIEF.md
# Register Result Latency Scoreboard

This block tracks, for an in-order issue pipeline, when the result of every in-flight instruction can be consumed. When an instruction issues, its destination register gets a down-counter loaded from the latency of the producing class. The counter then runs down by one every cycle. The entry also keeps the producer class, so that a consumer can be released early where a dedicated forwarding path exists.

Each cycle the issue stage gives the class of the candidate instruction and up to three source register indices. For each source, the block answers whether the operand can be used this cycle. The early paths are:
- unshifted operands from ALU results;
- integer multiply-accumulate chains;
- single- and double-precision floating-point multiply-accumulate chains;
- floating-point loads feeding floating-point arithmetic.

It also raises a single stall when any valid source is not ready. Registers 0 to 15 are the integer file and 16 to 47 the floating-point file, so one index space serves both. A flush returns every entry to ready.

Top module: `rls_scoreboard`

## Requirements
- R1: After reset every register reads ready for every consumer class, and `stall` is 0 even with all sources valid.
- R2: Producer class 0 (ALU) gives 2 cycles of latency, reduced to 1 for consumer class 1 (ALU or multiply taking the operand unshifted) and consumer class 2 (integer accumulate input). "Latency L" means that a consumer querying L cycles after the producer's issue cycle is ready, and one querying at L-1 cycles is not.
- R3: Producer class 1 (integer multiply) gives 2, reduced to 1 only for consumer class 2 (integer accumulate input).
- R4: Producer class 2 (load up to 8 bytes) gives 2. Producer class 3 (12- or 16-byte load) gives 3.
- R5: Producer class 4 (FP add, compare, convert, move) gives 4. Class 5 (FP 8-bit immediate constant) gives 3. Class 11 (core-to-FP transfer) gives 4. Class 12 (FP-to-core transfer) gives 2.
- R6: Producer class 6 (single FP multiply) gives 4. Class 7 (single FP multiply-accumulate) gives 8, reduced to 4 only for consumer class 3 (single accumulate input).
- R7: Producer class 8 (double FP multiply) gives 7. Class 9 (double FP multiply-accumulate) gives 11, reduced to 7 only for consumer class 4 (double accumulate input).
- R8: Producer class 10 (FP load) gives 4, reduced to 2 for consumer class 5 (FP arithmetic or FP-to-core transfer). Consumer class 0 is the general case, with no reduction.
- R9: A new issue to a register replaces its counter and class, so readiness follows the newest producer. Other registers are not disturbed.
- R10: A `flush` makes every register ready from the next cycle. An issue in the same cycle as a flush is discarded.
- R11: `src_ready[i]` reports the register state regardless of `src_valid[i]`. `stall` is 1 exactly when some valid source is not ready.
- R12: Register indices 48 and above are outside the file: an issue to them changes nothing, and a query of them reads ready.
- R13: A query sees the state at the start of the cycle, so an issue in the same cycle is not visible until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries to ready |
| iss_valid | input | 1 | An instruction with a destination issues this cycle |
| iss_class | input | 4 | Producer class of the issuing instruction |
| iss_dst | input | 6 | Destination register index |
| cons_class | input | 3 | Consumer class of the candidate instruction |
| src_valid | input | 3 | Per-source operand present |
| src_reg | input | 18 | Source indices, source i at bits [6i+5:6i] |
| src_ready | output | 3 | Per-source operand usable this cycle |
| stall | output | 1 | Some valid source is not ready |

## Verification
A counter that is loaded wrongly or runs down wrongly shows up as `src_ready` rising one or more cycles early or late. The bench therefore measures the exact cycle of release for every producer and consumer pairing, counted from the issue. A wrong stored class appears only under the consumer class that owns the forwarding path: a fast path is lost, or a non-matching consumer is released too soon. A missed clear or a stray write shows up on the very next cycle, as a register that stays busy after a flush or as a bystander register that reads busy.

// File: rtl/rls_pkg.sv
package rls_pkg;
   localparam int LAT_W = 4;
   localparam int CON_W = 3;

   typedef enum logic [LAT_W-1:0] {
      PC_ALU = 4'd0, PC_IMUL = 4'd1, PC_LDS = 4'd2, PC_LDL = 4'd3,
      PC_FADD = 4'd4, PC_FCONST = 4'd5, PC_FMULS = 4'd6, PC_FMACS = 4'd7,
      PC_FMULD = 4'd8, PC_FMACD = 4'd9, PC_FLOAD = 4'd10, PC_R2F = 4'd11,
      PC_F2R = 4'd12
   } prod_e;

   typedef enum logic [CON_W-1:0] {
      CC_GEN = 3'd0, CC_UNSH = 3'd1, CC_IMACC = 3'd2, CC_SMACC = 3'd3,
      CC_DMACC = 3'd4, CC_FPUSE = 3'd5
   } cons_e;

   // full latency of a producer towards an unrelated consumer
   function automatic logic [LAT_W-1:0] base_lat(input logic [LAT_W-1:0] p);
      case (p)
         PC_ALU, PC_IMUL, PC_LDS, PC_F2R: base_lat = 4'd2;
         PC_LDL, PC_FCONST:               base_lat = 4'd3;
         PC_FADD, PC_FMULS, PC_FLOAD,
         PC_R2F:                          base_lat = 4'd4;
         PC_FMULD:                        base_lat = 4'd7;
         PC_FMACS:                        base_lat = 4'd8;
         PC_FMACD:                        base_lat = 4'd11;
         default:                         base_lat = 4'd0;
      endcase
   endfunction

   // cycles a forwarding path removes for a producer/consumer pair
   function automatic logic [LAT_W-1:0] discount(input logic [LAT_W-1:0] p,
                                                 input logic [CON_W-1:0] c);
      discount = 4'd0;
      case (p)
         PC_ALU:   if (c == CC_UNSH || c == CC_IMACC) discount = 4'd1;
         PC_IMUL:  if (c == CC_IMACC) discount = 4'd1;
         PC_FMACS: if (c == CC_SMACC) discount = 4'd4;
         PC_FMACD: if (c == CC_DMACC) discount = 4'd4;
         PC_FLOAD: if (c == CC_FPUSE) discount = 4'd2;
         default:  discount = 4'd0;
      endcase
   endfunction
endpackage

// File: rtl/rls_entry.sv
module rls_entry #(
   parameter int CNT_W = 4,
   parameter int CLS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [CLS_W-1:0] wr_cls,
   output logic [CNT_W-1:0] cnt,
   output logic [CLS_W-1:0] cls
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         cls <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (wr) begin
         cnt <= wr_cnt;
         cls <= wr_cls;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/rls_rdport.sv
module rls_rdport
   import rls_pkg::*;
#(
   parameter int NREG  = 48,
   parameter int IDX_W = 6,
   parameter int CNT_W = 4
) (
   input  logic [CNT_W-1:0] cnt_arr [NREG],
   input  logic [LAT_W-1:0] cls_arr [NREG],
   input  logic [IDX_W-1:0] idx,
   input  logic [CON_W-1:0] cons,
   output logic             ready
);
   logic             in_range;
   logic [IDX_W-1:0] sel;
   logic [CNT_W-1:0] disc;

   always_comb begin
      in_range = ({1'b0, idx} < (IDX_W+1)'(NREG));
      sel      = in_range ? idx : '0;
      disc     = CNT_W'(discount(cls_arr[sel], cons));
      ready    = !in_range || (cnt_arr[sel] <= disc);
   end
endmodule

// File: rtl/rls_scoreboard.sv
module rls_scoreboard
   import rls_pkg::*;
#(
   parameter int NUM_INT = 16,
   parameter int NUM_FP  = 32,
   parameter int NSRC    = 3,
   parameter int IDX_W   = 6,
   parameter int CNT_W   = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  iss_valid,
   input  logic [3:0]            iss_class,
   input  logic [IDX_W-1:0]      iss_dst,
   input  logic [2:0]            cons_class,
   input  logic [NSRC-1:0]       src_valid,
   input  logic [NSRC*IDX_W-1:0] src_reg,
   output logic [NSRC-1:0]       src_ready,
   output logic                  stall
);
   localparam int NREG = NUM_INT + NUM_FP;

   generate
      if (NREG > (1 << IDX_W)) begin : g_bad_idx
         $error("index width too small for register count");
      end
      if (CNT_W < LAT_W) begin : g_bad_cnt
         $error("counter width cannot hold longest latency");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q [NREG];
   logic [LAT_W-1:0] cls_q [NREG];
   logic [LAT_W-1:0] blat;
   logic [CNT_W-1:0] load_cnt;
   logic             iss_go;

   always_comb begin
      blat     = base_lat(iss_class);
      load_cnt = (blat == '0) ? '0 : CNT_W'(blat - 1'b1);
      iss_go   = iss_valid && !flush;
   end

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         rls_entry #(.CNT_W(CNT_W), .CLS_W(LAT_W)) u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (flush),
            .wr     (iss_go && ({1'b0, iss_dst} == (IDX_W+1)'(r))),
            .wr_cnt (load_cnt),
            .wr_cls (iss_class),
            .cnt    (cnt_q[r]),
            .cls    (cls_q[r])
         );
      end

      for (genvar s = 0; s < NSRC; s++) begin : g_src
         rls_rdport #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_port (
            .cnt_arr (cnt_q),
            .cls_arr (cls_q),
            .idx     (src_reg[s*IDX_W +: IDX_W]),
            .cons    (cons_class),
            .ready   (src_ready[s])
         );
      end
   endgenerate

   assign stall = |(src_valid & ~src_ready);
endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
   parameter int NREG  = 48,
   parameter int NSRC  = 3,
   parameter int IDX_W = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  flush,
   input logic                  iss_valid,
   input logic [3:0]            iss_class,
   input logic [IDX_W-1:0]      iss_dst,
   input logic [2:0]            cons_class,
   input logic [NSRC-1:0]       src_valid,
   input logic [NSRC*IDX_W-1:0] src_reg,
   input logic [NSRC-1:0]       src_ready,
   input logic                  stall
);
   p_reset_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (&src_ready));

   p_general_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(iss_valid && !flush && iss_class <= 4'd12
                              && {1'b0, iss_dst} < (IDX_W+1)'(NREG))
       && cons_class == 3'd0 && src_reg[IDX_W-1:0] == $past(iss_dst))
      |-> !src_ready[0]);

   p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(src_ready[0]) && $stable(src_reg[IDX_W-1:0])
       && $stable(cons_class) && !$past(iss_valid && iss_dst == src_reg[IDX_W-1:0]))
      |-> src_ready[0]);

   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (&src_ready));

   p_stall_on_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_valid & ~src_ready) != '0) |-> stall);

   p_no_stall_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid == '0) |-> !stall);

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_oor
         p_outside_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, src_reg[s*IDX_W +: IDX_W]} >= (IDX_W+1)'(NREG)) |-> src_ready[s]);
      end
   endgenerate
endmodule

bind rls_scoreboard rls_checker #(.NREG(NUM_INT + NUM_FP), .NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .iss_valid  (iss_valid),
   .iss_class  (iss_class),
   .iss_dst    (iss_dst),
   .cons_class (cons_class),
   .src_valid  (src_valid),
   .src_reg    (src_reg),
   .src_ready  (src_ready),
   .stall      (stall)
);

// File: tb/test_rls_scoreboard.sv
module test_rls_scoreboard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        iss_valid = 1'b0;
   logic [3:0]  iss_class = '0;
   logic [5:0]  iss_dst = '0;
   logic [2:0]  cons_class = '0;
   logic [2:0]  src_valid = '0;
   logic [17:0] src_reg = '0;
   logic [2:0]  src_ready;
   logic        stall;
   int          vectors = 0;
   int          miscompares = 0;

   always #10 clk = ~clk;

   rls_scoreboard i_rls_scoreboard (
      .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
      .iss_class(iss_class), .iss_dst(iss_dst), .cons_class(cons_class),
      .src_valid(src_valid), .src_reg(src_reg), .src_ready(src_ready),
      .stall(stall)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   // issue one producer, then count cycles until source 0 reads ready
   task automatic measure(input int p, input int c, input int dst,
                          input int exp, input string req);
      int k;
      do_flush();
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'(p); iss_dst = 6'(dst);
      src_reg[5:0] = 6'(dst); cons_class = 3'(c);
      #1 chk(src_ready[0] == 1'b1, "R13", "same-cycle issue hidden", src_ready[0], 1);
      @(negedge clk); iss_valid = 1'b0;
      k = 1;
      #1;
      while (!src_ready[0] && k < 20) begin
         @(negedge clk); #1; k++;
      end
      chk(k == exp, req, $sformatf("latency prod %0d cons %0d", p, c), k, exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      src_valid = 3'b111; src_reg = {6'd47, 6'd16, 6'd0}; cons_class = 3'd0;
      #1;
      chk(src_ready == 3'b111, "R1", "ready after reset", src_ready, 7);
      chk(stall == 1'b0, "R1", "no stall after reset", stall, 0);
      src_valid = '0;
   endtask

   task automatic t_latencies();
      measure(0, 0, 3, 2, "R2");  measure(0, 1, 3, 1, "R2");
      measure(0, 2, 4, 1, "R2");  measure(0, 5, 4, 2, "R2");
      measure(1, 0, 5, 2, "R3");  measure(1, 2, 5, 1, "R3");
      measure(1, 1, 6, 2, "R3");
      measure(2, 0, 7, 2, "R4");  measure(3, 0, 8, 3, "R4");
      measure(4, 0, 20, 4, "R5"); measure(4, 5, 20, 4, "R5");
      measure(5, 0, 21, 3, "R5"); measure(11, 0, 22, 4, "R5");
      measure(12, 0, 9, 2, "R5");
      measure(6, 0, 23, 4, "R6");  measure(7, 0, 24, 8, "R6");
      measure(7, 3, 24, 4, "R6");  measure(7, 4, 25, 8, "R6");
      measure(8, 0, 26, 7, "R7");  measure(9, 0, 27, 11, "R7");
      measure(9, 4, 28, 7, "R7");  measure(9, 3, 29, 11, "R7");
      measure(10, 0, 30, 4, "R8"); measure(10, 5, 31, 2, "R8");
      measure(10, 1, 31, 4, "R8");
   endtask

   task automatic t_overwrite();
      int k;
      do_flush();
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'd9; iss_dst = 6'd40;
      @(negedge clk);
      iss_class = 4'd0;
      @(negedge clk);
      iss_valid = 1'b0;
      src_reg[5:0] = 6'd40; src_reg[11:6] = 6'd41; cons_class = 3'd0;
      k = 1; #1;
      chk(src_ready[1] == 1'b1, "R9", "bystander reg untouched", src_ready[1], 1);
      while (!src_ready[0] && k < 20) begin
         @(negedge clk); #1; k++;
      end
      chk(k == 2, "R9", "newest producer governs", k, 2);
   endtask

   task automatic t_flush();
      do_flush();
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'd9; iss_dst = 6'd35;
      @(negedge clk);
      flush = 1'b1; iss_dst = 6'd36;
      @(negedge clk);
      flush = 1'b0; iss_valid = 1'b0;
      src_reg[5:0] = 6'd35; src_reg[11:6] = 6'd36; cons_class = 3'd0;
      #1;
      chk(src_ready[0] == 1'b1, "R10", "flush clears busy reg", src_ready[0], 1);
      chk(src_ready[1] == 1'b1, "R10", "issue with flush dropped", src_ready[1], 1);
   endtask

   task automatic t_stall();
      do_flush();
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'd8; iss_dst = 6'd17;
      @(negedge clk);
      iss_valid = 1'b0;
      src_reg = {6'd2, 6'd3, 6'd17}; src_valid = 3'b011; cons_class = 3'd0;
      #1;
      chk(src_ready == 3'b110, "R11", "per-source readiness", src_ready, 6);
      chk(stall == 1'b1, "R11", "stall on busy valid source", stall, 1);
      src_valid = 3'b110;
      #1;
      chk(stall == 1'b0, "R11", "invalid busy source ignored", stall, 0);
      chk(src_ready[0] == 1'b0, "R11", "ready independent of valid", src_ready[0], 0);
      src_valid = '0;
   endtask

   task automatic t_outside();
      do_flush();
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'd9; iss_dst = 6'd50;
      @(negedge clk);
      iss_valid = 1'b0;
      src_reg = {6'd63, 6'd2, 6'd50}; cons_class = 3'd0;
      #1;
      chk(src_ready == 3'b111, "R12", "outside index ready, no alias", src_ready, 7);
   endtask

   initial begin
      #(20 * 200000);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latencies();
      t_overwrite();
      t_flush();
      t_stall();
      t_outside();
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule